// File: doc/BRIEF.md
# Power-on and warm reset sequencer

This block turns a raw active-low reset pin, a supply-good flag and a supply-lockout flag into the internal reset sequence of a device that holds an embedded flash engine. It tells the first reset after the supply comes up apart from a reset issued while the device is already running. The first kind needs a long low pulse and is followed by a configuration-load phase. The second kind needs only a short pulse and skips the load. Both kinds end in a common hold-off window, and memory access is granted only when that window has expired.

The pin is brought in through a two-flop synchronizer. A counter then measures how long it stays low, so a pulse shorter than the minimum that applies has no effect. Entering the configuration load sends a one-cycle register-clear strobe and forces the flash engine to read mode. A qualified warm reset that arrives while the flash engine is programming or erasing sends a one-cycle abort. Requests to start a flash write pass only while access is granted and the lockout flag is clear.

The core flops use `rst_core_n`, which clears them asynchronously and is expected to be released in step with `clk`. All cycle counts below assume the default synchronizer depth of 2.

Top module: `rst_seq_top`

## Requirements
- R1: While `rst_core_n` is low, `ready`, `cfg_load_active`, `reg_clear`, `flash_abort`, `logic_valid` and `wr_go` are all 0.
- R2: After `supply_good` rises with `ext_rst_n` low, a release of `ext_rst_n` after fewer than T_POR_PULSE low cycles is ignored: no configuration load starts and `ready` stays 0.
- R3: A release after at least T_POR_PULSE low cycles raises `cfg_load_active` 3 cycles after the release edge is driven, for exactly T_CFG_LOAD cycles. `reg_clear` and `flash_abort` each pulse exactly once, in the first cycle of the load.
- R4: After a power-on release, `ready` rises exactly 3 + T_CFG_LOAD + T_OPR cycles after the release edge is driven (T_OPR hold-off cycles after the load).
- R5: `logic_valid` is 0 from power-up until the configuration load completes, then stays 1 through every warm reset.
- R6: While running, a low pulse of T_WARM_PULSE - 1 cycles leaves `ready` at 1. A low pulse of T_WARM_PULSE cycles or longer drops `ready` T_WARM_PULSE + 2 cycles after the falling edge is driven.
- R7: After a warm release, `ready` rises 3 + T_OPR cycles after the release edge is driven, with no `cfg_load_active` and no `reg_clear` in between.
- R8: `flash_abort` pulses exactly once when a warm reset qualifies while `flash_busy` is 1, and stays 0 when `flash_busy` is 0.
- R9: `wr_go` is 1 exactly when `wr_req` is 1, `ready` is 1 and `lockout` is 0.
- R10: When `supply_good` falls, `ready` and `logic_valid` are 0 from the next cycle. The restart that follows again needs the long power-on pulse; a warm-length pulse does not restart the device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_core_n | input | 1 | Asynchronous active-low clear of the sequencer flops |
| ext_rst_n | input | 1 | Raw active-low reset pin, asynchronous to clk |
| supply_good | input | 1 | Supply steady above its operating minimum |
| lockout | input | 1 | Supply below the write-lockout threshold |
| flash_busy | input | 1 | Flash engine is in a program or erase operation |
| wr_req | input | 1 | Request to start a flash write cycle |
| ready | output | 1 | Memory access allowed |
| cfg_load_active | output | 1 | Configuration load in progress |
| reg_clear | output | 1 | One-cycle register-clear strobe |
| flash_abort | output | 1 | One-cycle command that stops program or erase and returns the flash engine to read mode |
| logic_valid | output | 1 | Programmable-logic outputs are valid |
| wr_go | output | 1 | Qualified start of a flash write cycle |

## Verification
The bench sends pulses one cycle below and exactly at each minimum width. An off-by-one in the width counter would then either accept a pulse that is one cycle short or drop a qualified reset. It measures the exact cycle in which the configuration load starts and in which `ready` returns after both kinds of reset. A missing or doubled hold-off, or a configuration load that runs on a warm reset, moves those cycles. It checks that after a loss of supply a warm-length pulse no longer restarts the device, which catches a power-on flag that is never set again. It also checks that the abort follows the busy flag and that writes are blocked under lockout.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [2:0] {
    ST_POWER_WAIT  = 3'd0,
    ST_POR_ASSERT  = 3'd1,
    ST_CFG_LOAD    = 3'd2,
    ST_HOLD_OFF    = 3'd3,
    ST_RUN         = 3'd4,
    ST_WARM_ASSERT = 3'd5
  } rs_state_e;
endpackage

// File: rtl/rs_sync.sv
module rs_sync #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rs_sat_cnt.sv
module rs_sat_cnt #(
  parameter int W   = 4,
  parameter int MAX = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt = cnt;
    if (clr)                        cnt_nxt = '0;
    else if (en && cnt != W'(MAX))  cnt_nxt = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end
endmodule

// File: rtl/rs_fsm.sv
module rs_fsm
  import rs_pkg::*;
#(
  parameter int T_POR_PULSE  = 64,
  parameter int T_WARM_PULSE = 8,
  parameter int T_CFG_LOAD   = 16,
  parameter int T_OPR        = 20,
  parameter int LW           = 7,
  parameter int PW           = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          supply_good,
  input  logic          rst_sync,
  input  logic          flash_busy,
  input  logic [LW-1:0] lo_cnt,
  input  logic [PW-1:0] ph_cnt,
  output rs_state_e     state,
  output logic          state_chg,
  output logic          ready,
  output logic          cfg_load_active,
  output logic          reg_clear,
  output logic          flash_abort,
  output logic          logic_valid
);
  localparam logic [LW-1:0] POR_MIN  = LW'(T_POR_PULSE);
  localparam logic [LW-1:0] POR_M1   = LW'(T_POR_PULSE - 1);
  localparam logic [LW-1:0] WARM_M1  = LW'(T_WARM_PULSE - 1);
  localparam logic [PW-1:0] CFG_LAST = PW'(T_CFG_LOAD - 1);
  localparam logic [PW-1:0] OPR_LAST = PW'(T_OPR - 1);

  rs_state_e state_nxt;
  logic      sg_q;
  logic      por_flag, por_flag_nxt;
  logic      valid_nxt, abort_nxt;
  logic      qualified;

  // a running reset qualifies once it has been low long enough for the mode in force
  assign qualified = !rst_sync && (lo_cnt >= (por_flag ? POR_M1 : WARM_M1));

  always_comb begin
    state_nxt = state;
    unique case (state)
      ST_POWER_WAIT:  if (supply_good) state_nxt = ST_POR_ASSERT;
      ST_POR_ASSERT:  if (rst_sync && lo_cnt >= POR_MIN) state_nxt = ST_CFG_LOAD;
      ST_CFG_LOAD:    if (ph_cnt == CFG_LAST) state_nxt = ST_HOLD_OFF;
      ST_HOLD_OFF: begin
        if (qualified)               state_nxt = por_flag ? ST_POR_ASSERT : ST_WARM_ASSERT;
        else if (ph_cnt == OPR_LAST) state_nxt = ST_RUN;
      end
      ST_RUN:         if (qualified) state_nxt = por_flag ? ST_POR_ASSERT : ST_WARM_ASSERT;
      ST_WARM_ASSERT: if (rst_sync) state_nxt = ST_HOLD_OFF;
      default:        state_nxt = ST_POWER_WAIT;
    endcase
    if (!supply_good) state_nxt = ST_POWER_WAIT;
  end

  assign state_chg = (state_nxt != state);

  always_comb begin
    por_flag_nxt = por_flag;
    if (state_nxt == ST_RUN)    por_flag_nxt = 1'b0;
    if (supply_good && !sg_q)   por_flag_nxt = 1'b1;

    valid_nxt = logic_valid;
    if (state == ST_CFG_LOAD && state_nxt == ST_HOLD_OFF) valid_nxt = 1'b1;
    if (state_nxt == ST_POWER_WAIT)                       valid_nxt = 1'b0;

    abort_nxt = (state_nxt == ST_CFG_LOAD && state != ST_CFG_LOAD) ||
                (state_nxt == ST_WARM_ASSERT && state != ST_WARM_ASSERT && flash_busy);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_POWER_WAIT;
      sg_q        <= 1'b0;
      por_flag    <= 1'b0;
      logic_valid <= 1'b0;
      flash_abort <= 1'b0;
    end else begin
      state       <= state_nxt;
      sg_q        <= supply_good;
      por_flag    <= por_flag_nxt;
      logic_valid <= valid_nxt;
      flash_abort <= abort_nxt;
    end
  end

  assign ready           = (state == ST_RUN);
  assign cfg_load_active = (state == ST_CFG_LOAD);
  assign reg_clear       = (state == ST_CFG_LOAD) && (ph_cnt == '0);
endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top
  import rs_pkg::*;
#(
  parameter int T_POR_PULSE  = 64,
  parameter int T_WARM_PULSE = 8,
  parameter int T_CFG_LOAD   = 16,
  parameter int T_OPR        = 20,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_core_n,
  input  logic ext_rst_n,
  input  logic supply_good,
  input  logic lockout,
  input  logic flash_busy,
  input  logic wr_req,
  output logic ready,
  output logic cfg_load_active,
  output logic reg_clear,
  output logic flash_abort,
  output logic logic_valid,
  output logic wr_go
);
  localparam int LW   = $clog2(T_POR_PULSE + 1);
  localparam int PMAX = (T_CFG_LOAD > T_OPR) ? T_CFG_LOAD : T_OPR;
  localparam int PW   = $clog2(PMAX + 1);

  logic          rst_sync;
  logic [LW-1:0] lo_cnt;
  logic [PW-1:0] ph_cnt;
  rs_state_e     state;
  logic          state_chg;

  rs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
    .clk(clk), .rst_n(rst_core_n), .d(ext_rst_n), .q(rst_sync)
  );

  // low-width meter: only counts once the supply is up
  rs_sat_cnt #(.W(LW), .MAX(T_POR_PULSE)) u_lo_cnt (
    .clk(clk), .rst_n(rst_core_n),
    .clr(rst_sync || state == ST_POWER_WAIT),
    .en(!rst_sync), .cnt(lo_cnt)
  );

  // phase timer: restarts on every state change
  rs_sat_cnt #(.W(PW), .MAX(PMAX)) u_ph_cnt (
    .clk(clk), .rst_n(rst_core_n),
    .clr(state_chg), .en(1'b1), .cnt(ph_cnt)
  );

  rs_fsm #(
    .T_POR_PULSE(T_POR_PULSE), .T_WARM_PULSE(T_WARM_PULSE),
    .T_CFG_LOAD(T_CFG_LOAD), .T_OPR(T_OPR), .LW(LW), .PW(PW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_core_n), .supply_good(supply_good),
    .rst_sync(rst_sync), .flash_busy(flash_busy),
    .lo_cnt(lo_cnt), .ph_cnt(ph_cnt),
    .state(state), .state_chg(state_chg),
    .ready(ready), .cfg_load_active(cfg_load_active),
    .reg_clear(reg_clear), .flash_abort(flash_abort),
    .logic_valid(logic_valid)
  );

  assign wr_go = wr_req && ready && !lockout;
endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk (
  input logic clk,
  input logic rst_core_n,
  input logic supply_good,
  input logic lockout,
  input logic ready,
  input logic cfg_load_active,
  input logic reg_clear,
  input logic flash_abort,
  input logic logic_valid,
  input logic wr_go
);
  // R3
  reg_clear_pulse_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    reg_clear |=> !reg_clear);
  // R3
  abort_pulse_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    flash_abort |=> !flash_abort);
  // R3
  clear_in_load_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    reg_clear |-> cfg_load_active);
  // R5
  valid_after_load_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    $fell(cfg_load_active) && supply_good |-> logic_valid);
  // R5
  ready_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    ready |-> logic_valid);
  // R9
  lockout_blocks_wr_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    lockout |-> !wr_go);
  // R9
  wr_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    wr_go |-> ready);
  // R10
  power_loss_ready_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    !supply_good |=> !ready && !logic_valid);
  // R4
  load_excl_ready_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    cfg_load_active |-> !ready);
endmodule

bind rst_seq_top rst_seq_chk u_chk (
  .clk(clk), .rst_core_n(rst_core_n), .supply_good(supply_good),
  .lockout(lockout), .ready(ready), .cfg_load_active(cfg_load_active),
  .reg_clear(reg_clear), .flash_abort(flash_abort),
  .logic_valid(logic_valid), .wr_go(wr_go)
);

// File: tb/rst_seq_top_tb.sv
module rst_seq_top_tb;
  localparam int TP = 40;
  localparam int TW = 6;
  localparam int TC = 10;
  localparam int TO = 12;

  logic clk = 1'b0;
  logic rst_core_n, ext_rst_n, supply_good, lockout, flash_busy, wr_req;
  logic ready, cfg_load_active, reg_clear, flash_abort, logic_valid, wr_go;

  int checks = 0;
  int failures = 0;
  int first_cfg, cfg_cnt, rc_cnt, ab_cnt, rise_n, fall_n;

  always #10 clk = ~clk;

  rst_seq_top #(.T_POR_PULSE(TP), .T_WARM_PULSE(TW), .T_CFG_LOAD(TC), .T_OPR(TO)) u_dut (
    .clk(clk), .rst_core_n(rst_core_n), .ext_rst_n(ext_rst_n),
    .supply_good(supply_good), .lockout(lockout), .flash_busy(flash_busy),
    .wr_req(wr_req), .ready(ready), .cfg_load_active(cfg_load_active),
    .reg_clear(reg_clear), .flash_abort(flash_abort),
    .logic_valid(logic_valid), .wr_go(wr_go)
  );

  // {wr_req, lockout, expected wr_go} while running
  localparam logic [2:0] WR_VEC [4] = '{3'b000, 3'b101, 3'b110, 3'b010};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive the pin low now, release it after low_len negedges, observe total negedges
  task automatic pulse_window(input int low_len, input int total);
    logic prev;
    prev = ready;
    first_cfg = 0; cfg_cnt = 0; rc_cnt = 0; ab_cnt = 0; rise_n = 0; fall_n = 0;
    ext_rst_n = 1'b0;
    for (int n = 1; n <= total; n++) begin
      @(negedge clk);
      if (cfg_load_active) begin
        cfg_cnt++;
        if (first_cfg == 0) first_cfg = n;
      end
      if (reg_clear)   rc_cnt++;
      if (flash_abort) ab_cnt++;
      if (ready && !prev && rise_n == 0) rise_n = n;
      if (!ready && prev && fall_n == 0) fall_n = n;
      prev = ready;
      if (n == low_len) ext_rst_n = 1'b1;
    end
  endtask

  initial begin
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_core_n = 1'b0; ext_rst_n = 1'b0; supply_good = 1'b0;
    lockout = 1'b0; flash_busy = 1'b0; wr_req = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ready", ready, 0);
    chk("R1 cfg_load_active", cfg_load_active, 0);
    chk("R1 pulses", reg_clear | flash_abort, 0);
    chk("R1 logic_valid/wr_go", logic_valid | wr_go, 0);
    rst_core_n = 1'b1;
    wr_req = 1'b0;
    repeat (3) @(negedge clk);

    // R2 short power-on pulse ignored
    supply_good = 1'b1;
    pulse_window(TP - 10, 60);
    chk("R2 no cfg load after short pulse", cfg_load_active == 0 && cfg_cnt == 0, 1);
    chk("R2 ready stays low", rise_n + ready, 0);
    chk("R5 logic_valid low before load", logic_valid, 0);

    // R3 R4 qualified power-on pulse
    pulse_window(TP + 5, TP + 5 + TC + TO + 10);
    chk("R3 cfg start cycle", first_cfg, TP + 5 + 3);
    chk("R3 cfg length", cfg_cnt, TC);
    chk("R3 reg_clear count", rc_cnt, 1);
    chk("R3 flash_abort count", ab_cnt, 1);
    chk("R4 ready rise cycle", rise_n, TP + 5 + 3 + TC + TO);
    chk("R5 logic_valid after load", logic_valid, 1);

    // R9 write gating table
    foreach (WR_VEC[i]) begin
      wr_req = WR_VEC[i][2];
      lockout = WR_VEC[i][1];
      #5;
      chk($sformatf("R9 vector %0d", i), wr_go, WR_VEC[i][0]);
      @(negedge clk);
    end
    wr_req = 1'b0; lockout = 1'b0;

    // R6 warm pulse one cycle short
    pulse_window(TW - 1, 20);
    chk("R6 short warm pulse keeps ready", fall_n, 0);
    chk("R6 ready still high", ready, 1);

    // R6 R7 R8 long warm pulse, flash busy
    flash_busy = 1'b1;
    pulse_window(TW + 6, TW + 6 + TO + 10);
    flash_busy = 1'b0;
    chk("R6 warm ready drop cycle", fall_n, TW + 2);
    chk("R8 abort when busy", ab_cnt, 1);
    chk("R7 warm ready rise cycle", rise_n, TW + 6 + 3 + TO);
    chk("R7 no cfg/reg_clear on warm", cfg_cnt + rc_cnt, 0);
    chk("R5 logic_valid through warm", logic_valid, 1);

    // R6 R8 exact warm width, flash idle
    pulse_window(TW, TW + TO + 10);
    chk("R6 exact warm width qualifies", fall_n, TW + 2);
    chk("R8 no abort when idle", ab_cnt, 0);
    chk("R7 rise after exact warm", rise_n, TW + 3 + TO);

    // R9 write blocked while not ready
    wr_req = 1'b1;
    ext_rst_n = 1'b0;
    repeat (TW + 3) @(negedge clk);
    chk("R9 wr_go low while in reset", wr_go, 0);
    ext_rst_n = 1'b1;
    wr_req = 1'b0;
    repeat (TO + 6) @(negedge clk);
    chk("R7 running again", ready, 1);

    // R10 supply loss
    supply_good = 1'b0;
    @(negedge clk);
    chk("R10 ready low after supply loss", ready, 0);
    chk("R10 logic_valid low after supply loss", logic_valid, 0);
    repeat (3) @(negedge clk);
    supply_good = 1'b1;
    pulse_window(TW + 2, 60);
    chk("R10 warm-length pulse does not restart", rise_n + cfg_cnt, 0);
    pulse_window(TP + 5, TP + 5 + TC + TO + 10);
    chk("R10 long pulse restarts", rise_n, TP + 5 + 3 + TC + TO);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule